// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiplier with Signedness Modes

This unit multiplies two bytes and returns a 16-bit product. A two-bit mode input selects how the operands are read: both unsigned, both two's complement, or a two's-complement multiplicand with an unsigned multiplier. The product comes out as separate upper and lower bytes, meant for the high and low halves of a register pair. Two flags come with it: a zero flag and a carry flag.

A one-cycle start strobe launches an operation. The operands and the mode are captured at that edge. The result, the flags and a one-cycle valid pulse appear after the next rising edge, so latency is fixed at two clock cycles. Between those two edges a busy output is high, and any start seen then is dropped. A start in the cycle where valid is high is accepted, so operations can be issued back to back every two cycles. Choosing operand registers and checking which register indices are legal belong to the surrounding core.

Top module: `mul8x8_unit`

## Requirements
- R1: Mode 2'b00 multiplies both operands as unsigned values. The reserved code 2'b11 behaves the same as 2'b00.
- R2: Mode 2'b01 multiplies both operands as 8-bit two's-complement values and returns the low 16 bits of the signed product (for example 0x80 x 0x80 gives 0x4000).
- R3: Mode 2'b10 reads op_a as two's complement and op_b as unsigned (for example 0xFF x 0xFF gives 0xFF01).
- R4: prod_hi carries product bits 15..8 and prod_lo carries bits 7..0.
- R5: flag_z is 1 exactly when all 16 product bits are 0.
- R6: flag_c equals product bit 15.
- R7: Suppose start is sampled high at rising edge k while busy is low. Then busy is high from edge k until edge k+1. At edge k+1, busy falls and res_valid rises, and the new result is already on the outputs.
- R8: res_valid is high for exactly one cycle per accepted start.
- R9: A start sampled while busy is high is ignored. The operands applied with it never reach the outputs, and it produces no extra valid pulse.
- R10: Synchronous active-high reset clears busy, res_valid, both product bytes and both flags. The product bytes and flags then hold their value until the next result is loaded.
- R11: A start in the cycle where res_valid is high is accepted, which allows one operation every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when busy is low |
| op_a | input | 8 | Multiplicand byte |
| op_b | input | 8 | Multiplier byte |
| mode | input | 2 | 00 unsigned, 01 signed, 10 signed x unsigned, 11 as 00 |
| prod_hi | output | 8 | Product bits 15..8 |
| prod_lo | output | 8 | Product bits 7..0 |
| flag_z | output | 1 | Product is zero |
| flag_c | output | 1 | Product bit 15 |
| res_valid | output | 1 | One-cycle pulse when a new result is on the outputs |
| busy | output | 1 | Operation in flight; start is ignored |

## Verification
Two events can fall into the same cycle. The first is a new start strobe landing in the cycle where the previous result's valid pulse is on the outputs. This is provoked by issuing every sweep operation immediately after the prior one completes. Each result is judged against the product computed in the bench, and a missing or doubled valid pulse is also flagged. The second is a start arriving in the busy cycle while the first operation is still in flight. The bench applies different operands at that moment and checks that the first operation's product appears with a single valid pulse, and that the stray operands never appear.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic [1:0] {
        MODE_UU  = 2'b00,
        MODE_SS  = 2'b01,
        MODE_SU  = 2'b10,
        MODE_RSV = 2'b11
    } mul_mode_e;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        mul_mode_e       mode;
    } mul_req_t;

    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic              z;
        logic              c;
    } mul_res_t;

    // multiplicand is read as two's complement in signed and mixed modes
    function automatic logic a_signed(mul_mode_e m);
        return (m == MODE_SS) || (m == MODE_SU);
    endfunction

    // multiplier is read as two's complement only in signed mode
    function automatic logic b_signed(mul_mode_e m);
        return (m == MODE_SS);
    endfunction
endpackage

// File: rtl/mul8_extend.sv
module mul8_extend
    import mul8_pkg::*;
(
    input  mul_req_t           req,
    output logic signed [OP_W:0] xa,
    output logic signed [OP_W:0] xb
);
    // one guard bit per operand turns every mode into a signed product
    always_comb begin
        xa = {a_signed(req.mode) & req.a[OP_W-1], req.a};
        xb = {b_signed(req.mode) & req.b[OP_W-1], req.b};
    end
endmodule

// File: rtl/mul8_product.sv
module mul8_product
    import mul8_pkg::*;
(
    input  logic signed [OP_W:0] xa,
    input  logic signed [OP_W:0] xb,
    output mul_res_t             res
);
    localparam int FULL_W = 2 * (OP_W + 1);

    logic signed [FULL_W-1:0] full;

    always_comb begin
        full     = xa * xb;
        res.prod = full[PROD_W-1:0];
        res.z    = (full[PROD_W-1:0] == '0);
        res.c    = full[PROD_W-1];
    end
endmodule

// File: rtl/mul8_ctrl.sv
module mul8_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic res_valid
);
    assign accept = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            busy      <= accept;
            res_valid <= busy;
        end
    end

    // R7
    start_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R7
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && res_valid));
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    // R9
    no_valid_without_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !res_valid);
endmodule

// File: rtl/mul8x8_unit.sv
module mul8x8_unit
    import mul8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic [1:0]      mode,
    output logic [OP_W-1:0] prod_hi,
    output logic [OP_W-1:0] prod_lo,
    output logic            flag_z,
    output logic            flag_c,
    output logic            res_valid,
    output logic            busy
);
    logic                 accept;
    mul_req_t             req_q;
    logic signed [OP_W:0] xa;
    logic signed [OP_W:0] xb;
    mul_res_t             res_d;
    mul_res_t             res_q;

    mul8_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .accept    (accept),
        .busy      (busy),
        .res_valid (res_valid)
    );

    // operand capture at the accepting edge
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.a    <= op_a;
            req_q.b    <= op_b;
            req_q.mode <= mul_mode_e'(mode);
        end
    end

    mul8_extend u_ext (
        .req (req_q),
        .xa  (xa),
        .xb  (xb)
    );

    mul8_product u_prod (
        .xa  (xa),
        .xb  (xb),
        .res (res_d)
    );

    // result loads at the edge that ends the busy cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (busy) begin
            res_q <= res_d;
        end
    end

    assign prod_hi = res_q.prod[PROD_W-1:OP_W];
    assign prod_lo = res_q.prod[OP_W-1:0];
    assign flag_z  = res_q.z;
    assign flag_c  = res_q.c;

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flag_z == ({prod_hi, prod_lo} == '0)));
    // R6
    carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flag_c == prod_hi[OP_W-1]));
    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable({prod_hi, prod_lo, flag_z, flag_c}));
endmodule

// File: tb/test_mul8x8_unit.sv
module test_mul8x8_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] op_a;
    logic [7:0] op_b;
    logic [1:0] mode;
    logic [7:0] prod_hi;
    logic [7:0] prod_lo;
    logic       flag_z;
    logic       flag_c;
    logic       res_valid;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mul8x8_unit i_mul8x8_unit (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .mode(mode), .prod_hi(prod_hi), .prod_lo(prod_lo), .flag_z(flag_z),
        .flag_c(flag_c), .res_valid(res_valid), .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int expect_prod(input int a, input int b, input int m);
        int sa;
        int sb;
        sa = ((m == 1 || m == 2) && a >= 128) ? a - 256 : a;
        sb = (m == 1 && b >= 128) ? b - 256 : b;
        return (sa * sb) & 32'hFFFF;
    endfunction

    // called on a falling edge; returns on the falling edge of the valid cycle
    task automatic run_op(input int a, input int b, input int m, input string rq);
        int e;
        start = 1'b1; op_a = a[7:0]; op_b = b[7:0]; mode = m[1:0];
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && res_valid === 1'b0, "R7", "busy phase",
            {busy, res_valid}, 2'b10);
        @(negedge clk);
        e = expect_prod(a, b, m);
        chk(res_valid === 1'b1 && busy === 1'b0, "R7", "valid phase",
            {busy, res_valid}, 2'b01);
        chk({prod_hi, prod_lo} === e[15:0], rq, "product", {prod_hi, prod_lo}, e);
        chk(flag_z === (e == 0), "R5", "zero flag", flag_z, (e == 0));
        chk(flag_c === e[15], "R6", "carry flag", flag_c, e[15]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cv[5];
        cv = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({prod_hi, prod_lo, flag_z, flag_c, res_valid, busy} === '0, "R10",
            "reset state", {prod_hi, prod_lo, flag_z, flag_c, res_valid, busy}, 0);

        // named examples
        run_op(8'h80, 8'h80, 1, "R2");
        chk({prod_hi, prod_lo} === 16'h4000, "R2", "0x80*0x80", {prod_hi, prod_lo}, 16'h4000);
        run_op(8'hFF, 8'hFF, 2, "R3");
        chk({prod_hi, prod_lo} === 16'hFF01, "R3", "0xFF*0xFF", {prod_hi, prod_lo}, 16'hFF01);
        run_op(8'hFF, 8'hFF, 0, "R1");
        chk({prod_hi, prod_lo} === 16'hFE01, "R1", "0xFF*0xFF", {prod_hi, prod_lo}, 16'hFE01);
        // R11 start during the valid cycle, issued immediately above
        run_op(8'h12, 8'h34, 0, "R11");

        // corner grid, all four mode codes (11 behaves as unsigned, R1)
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) begin
                    int e;
                    run_op(cv[i], cv[j], m, (m == 1) ? "R2" : (m == 2) ? "R3" : "R1");
                    e = expect_prod(cv[i], cv[j], (m == 3) ? 0 : m);
                    chk(prod_hi === e[15:8] && prod_lo === e[7:0], "R4", "byte split",
                        {prod_hi, prod_lo}, e);
                end

        // sweep: every multiplicand against 32 multipliers per mode
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 32; j++)
                    run_op(a, (j * 8) ^ j, m, (m == 0) ? "R1" : (m == 1) ? "R2" : "R3");

        // R9 start while busy is ignored; R8 single pulse; R10 hold
        start = 1'b1; op_a = 8'h0B; op_b = 8'h0D; mode = 2'b00;
        @(negedge clk);
        op_a = 8'h00; op_b = 8'h55; mode = 2'b01;
        @(negedge clk);
        start = 1'b0;
        chk(res_valid === 1'b1, "R9", "first result valid", res_valid, 1);
        chk({prod_hi, prod_lo} === 16'h008F, "R9", "busy start ignored",
            {prod_hi, prod_lo}, 16'h008F);
        @(negedge clk);
        chk(res_valid === 1'b0 && busy === 1'b0, "R8", "no second pulse",
            {busy, res_valid}, 0);
        repeat (3) @(negedge clk);
        chk({prod_hi, prod_lo, flag_z, flag_c} === {16'h008F, 2'b00}, "R10",
            "result held", {prod_hi, prod_lo, flag_z, flag_c}, {16'h008F, 2'b00});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule